// File: doc/BRIEF.md
# Unit-Stride Vector Load/Store Streamer

This block moves a whole vector between a word-addressed memory port and a vector register file. A command names the direction, a base address, a vector register and a vector length from 1 to 64. Element i always uses memory word base + i, and the address wraps at the width of the address port. Elements 0 through length-1 are moved one per clock. No other element or word is touched.

A load sends one read request per cycle. Every returned element is written into the register file exactly LATENCY cycles (12 by default) after its request. A token delay line sets that timing, and a small response queue holds data that memory returned early. A store reads one register element per cycle. It issues the matching memory write in the following cycle, carrying the data that the register file returned.

While a transfer is in progress, `busy` is high and further commands are refused. A single-cycle `done` pulse follows the final element. For a load, the total time is the vector length plus the startup latency.

Top module: `vls_stream_unit`

## Requirements
- R1: After reset, and after any reset during a transfer, `busy`, `done`, `mem_req`, `rf_we` and `rf_re` are low and `cmd_ready` is high.
- R2: A command is accepted at a clock edge where `cmd_valid` is high, `busy` is low and `cmd_vl` is in 1..64. `busy` is high in the first cycle after that edge. `cmd_ready` equals not `busy`.
- R3: A command whose `cmd_vl` is 0 or greater than 64 is ignored. `busy` stays low and no memory or register-file access follows.
- R4: A load (`cmd_store`=0) issues its read requests in cycles 0..VL-1, counted from the first cycle after acceptance. Each request has `mem_we`=0 and the request in cycle i has address (base + i) modulo 2^ADDR_W.
- R5: For a load, element i is written to element i of the chosen register exactly LATENCY cycles after its read request. Its data is the i-th response. Writes come one per cycle with rising element index. Memory must answer in request order within LATENCY-1 cycles.
- R6: A store (`cmd_store`=1) reads register element i in cycle i, and the register file returns the data one cycle later. In cycle i+1 the store issues a write with `mem_we`=1, address base + i and that data.
- R7: A transfer makes exactly VL memory requests. Memory words outside the range and register elements at index VL or above are left unchanged.
- R8: `busy` stays high for VL+LATENCY cycles for a load and VL+1 cycles for a store. Commands presented while `busy` is high are refused and have no effect.
- R9: `done` is high for exactly one cycle, the first cycle in which `busy` is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_store | input | 1 | 0 = load, 1 = store |
| cmd_base | input | ADDR_W | Word address of element 0 |
| cmd_vreg | input | $clog2(NUM_VREGS) | Vector register index |
| cmd_vl | input | $clog2(NUM_ELEMS+1) | Vector length |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request word address |
| mem_wdata | output | ELEM_W | Write data |
| mem_rvalid | input | 1 | Read response valid (in order) |
| mem_rdata | input | ELEM_W | Read response data |
| rf_we | output | 1 | Register-file element write |
| rf_wreg | output | $clog2(NUM_VREGS) | Written register |
| rf_welem | output | $clog2(NUM_ELEMS) | Written element index |
| rf_wdata | output | ELEM_W | Written element data |
| rf_re | output | 1 | Register-file element read |
| rf_rreg | output | $clog2(NUM_VREGS) | Read register |
| rf_relem | output | $clog2(NUM_ELEMS) | Read element index |
| rf_rdata | input | ELEM_W | Read data, valid the cycle after `rf_re` |

## Verification
The bench builds the unit with ADDR_W=8 and NUM_VREGS=4, and keeps 64 elements of 64 bits and the 12-cycle latency. The 8-bit address lets a 256-word memory model cover the whole address space. A transfer that starts near the top of the space therefore wraps back to word 0, and every word outside the range can be compared after each command. The memory model answers reads after 3 cycles, so the response queue really holds early data before the delay line releases it.

// File: rtl/vls_pkg.sv
package vls_pkg;

    // Direction of a vector transfer; the encoding matches cmd_store.
    typedef enum logic {
        VOP_LOAD  = 1'b0,
        VOP_STORE = 1'b1
    } vop_e;

endpackage

// File: rtl/vls_delay_line.sv
// Fixed-length token pipeline: a pulse on in_valid reappears on
// out_valid exactly DEPTH cycles later.
module vls_delay_line #(
    parameter int DEPTH = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic out_valid
);

    logic [DEPTH-1:0] pipe_d, pipe_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb pipe_d = in_valid;
        end else begin : g_chain
            always_comb pipe_d = {pipe_q[DEPTH-2:0], in_valid};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q[DEPTH-1];

endmodule

// File: rtl/vls_resp_fifo.sv
// Holds memory read data that arrives before its scheduled write slot.
module vls_resp_fifo #(
    parameter int WIDTH      = 64,
    parameter int DEPTH_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data
);

    localparam int DEPTH = 1 << DEPTH_LOG2;

    typedef struct packed {
        logic [DEPTH_LOG2-1:0] wp;
        logic [DEPTH_LOG2-1:0] rp;
        logic [DEPTH_LOG2:0]   cnt;
    } fptr_t;

    fptr_t            f_d, f_q;
    logic [WIDTH-1:0] slot_q [DEPTH];

    always_comb begin
        f_d = f_q;
        if (push) f_d.wp = f_q.wp + 1'b1;
        if (pop)  f_d.rp = f_q.rp + 1'b1;
        case ({push, pop})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[f_q.wp] <= push_data;
    end

    assign pop_data = slot_q[f_q.rp];

    // R5: the response for a scheduled write must already be queued.
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (f_q.cnt != '0));

    // R5: in-order responses never exceed the queue.
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (f_q.cnt != (DEPTH_LOG2+1)'(DEPTH)));

endmodule

// File: rtl/vls_stream_unit.sv
module vls_stream_unit
    import vls_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ELEM_W    = 64,
    parameter int NUM_ELEMS = 64,
    parameter int NUM_VREGS = 8,
    parameter int LATENCY   = 12,
    localparam int LEN_W     = $clog2(NUM_ELEMS + 1),
    localparam int IDX_W     = $clog2(NUM_ELEMS),
    localparam int VREG_W    = $clog2(NUM_VREGS),
    localparam int FIFO_LOG2 = $clog2(LATENCY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_store,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [VREG_W-1:0] cmd_vreg,
    input  logic [LEN_W-1:0]  cmd_vl,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ELEM_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [ELEM_W-1:0] mem_rdata,
    output logic              rf_we,
    output logic [VREG_W-1:0] rf_wreg,
    output logic [IDX_W-1:0]  rf_welem,
    output logic [ELEM_W-1:0] rf_wdata,
    output logic              rf_re,
    output logic [VREG_W-1:0] rf_rreg,
    output logic [IDX_W-1:0]  rf_relem,
    input  logic [ELEM_W-1:0] rf_rdata
);

    typedef struct packed {
        logic              busy;
        vop_e              op;
        logic [ADDR_W-1:0] base;
        logic [VREG_W-1:0] vreg;
        logic [LEN_W-1:0]  vl;
        logic [LEN_W-1:0]  iss;      // elements requested (load) or read (store)
        logic [LEN_W-1:0]  cmp;      // elements completed
        logic              rd_pend;  // store: register data returns this cycle
        logic              done;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              vl_ok, accept, issuing, load_req, rd_issue;
    logic              tok_out, store_wr, complete, last_elem;
    logic [ELEM_W-1:0] fifo_head;

    assign vl_ok     = (cmd_vl != '0) && (cmd_vl <= LEN_W'(NUM_ELEMS));
    assign accept    = cmd_valid && !c_q.busy && vl_ok;
    assign issuing   = c_q.busy && (c_q.iss != c_q.vl);
    assign load_req  = issuing && (c_q.op == VOP_LOAD);
    assign rd_issue  = issuing && (c_q.op == VOP_STORE);
    assign store_wr  = c_q.rd_pend;
    assign complete  = tok_out || store_wr;
    assign last_elem = complete && (c_q.cmp == c_q.vl - 1'b1);

    always_comb begin
        c_d         = c_q;
        c_d.done    = 1'b0;
        c_d.rd_pend = rd_issue;
        if (accept) begin
            c_d.busy = 1'b1;
            c_d.op   = vop_e'(cmd_store);
            c_d.base = cmd_base;
            c_d.vreg = cmd_vreg;
            c_d.vl   = cmd_vl;
            c_d.iss  = '0;
            c_d.cmp  = '0;
        end
        if (issuing)  c_d.iss = c_q.iss + 1'b1;
        if (complete) c_d.cmp = c_q.cmp + 1'b1;
        if (last_elem) begin
            c_d.busy = 1'b0;
            c_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // Startup latency model: each load request reappears LATENCY cycles later.
    vls_delay_line #(
        .DEPTH (LATENCY)
    ) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (load_req),
        .out_valid (tok_out)
    );

    vls_resp_fifo #(
        .WIDTH      (ELEM_W),
        .DEPTH_LOG2 (FIFO_LOG2)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (mem_rvalid),
        .push_data (mem_rdata),
        .pop       (tok_out),
        .pop_data  (fifo_head)
    );

    assign cmd_ready = !c_q.busy;
    assign busy      = c_q.busy;
    assign done      = c_q.done;

    assign mem_req   = load_req || store_wr;
    assign mem_we    = store_wr;
    assign mem_addr  = c_q.base + (store_wr ? ADDR_W'(c_q.cmp) : ADDR_W'(c_q.iss));
    assign mem_wdata = rf_rdata;

    assign rf_we     = tok_out;
    assign rf_wreg   = c_q.vreg;
    assign rf_welem  = IDX_W'(c_q.cmp);
    assign rf_wdata  = fifo_head;

    assign rf_re     = rd_issue;
    assign rf_rreg   = c_q.vreg;
    assign rf_relem  = IDX_W'(c_q.iss);

    // R3: an out-of-range length never starts a transfer.
    p_bad_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && !vl_ok) |=> !busy);

    // R4: consecutive memory requests walk up one word at a time.
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R5: register writes in consecutive cycles target consecutive elements.
    p_elem_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && $past(rf_we)) |-> (rf_welem == $past(rf_welem) + 1'b1));

    // R6: every register read of a store is followed by its memory write.
    p_store_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_re |=> (mem_req && mem_we));

    // R8: no command is taken while a transfer runs.
    p_hold_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rf_wreg));

    // R9: the completion pulse lasts one cycle and marks the end of busy.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

// File: tb/tb_vls_stream_unit.sv
`timescale 1ns/1ps
module tb_vls_stream_unit;

    localparam int AW  = 8;
    localparam int EW  = 64;
    localparam int NE  = 64;
    localparam int NV  = 4;
    localparam int LAT = 12;
    localparam int MLAT = 3;
    localparam int MW  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic          cmd_store = 1'b0;
    logic [AW-1:0] cmd_base = '0;
    logic [1:0]    cmd_vreg = '0;
    logic [6:0]    cmd_vl = '0;
    logic          busy, done, mem_req, mem_we, mem_rvalid;
    logic [AW-1:0] mem_addr;
    logic [EW-1:0] mem_wdata, mem_rdata, rf_wdata, rf_rdata;
    logic          rf_we, rf_re;
    logic [1:0]    rf_wreg, rf_rreg;
    logic [5:0]    rf_welem, rf_relem;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vls_stream_unit #(
        .ADDR_W (AW), .ELEM_W (EW), .NUM_ELEMS (NE), .NUM_VREGS (NV), .LATENCY (LAT)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_store (cmd_store),
        .cmd_base (cmd_base), .cmd_vreg (cmd_vreg), .cmd_vl (cmd_vl),
        .busy (busy), .done (done),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rvalid (mem_rvalid), .mem_rdata (mem_rdata),
        .rf_we (rf_we), .rf_wreg (rf_wreg), .rf_welem (rf_welem), .rf_wdata (rf_wdata),
        .rf_re (rf_re), .rf_rreg (rf_rreg), .rf_relem (rf_relem), .rf_rdata (rf_rdata)
    );

    function automatic logic [EW-1:0] mpat(int a);
        return {32'hC0DE0000 + 32'(a), 32'(a * 7 + 3)};
    endfunction

    function automatic logic [EW-1:0] rpat(int v, int e);
        return {16'(v), 16'hBEEF, 32'(e * 13 + 1)};
    endfunction

    // Memory model: fixed 3-cycle in-order read latency.
    logic [EW-1:0] mem_m [MW];
    logic [EW-1:0] rd_pipe [MLAT];
    logic [MLAT-1:0] rv_pipe;
    assign mem_rvalid = rv_pipe[MLAT-1];
    assign mem_rdata  = rd_pipe[MLAT-1];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < MW; a++) mem_m[a] <= mpat(a);
            rv_pipe <= '0;
        end else begin
            if (mem_req && mem_we) mem_m[mem_addr] <= mem_wdata;
            rv_pipe <= {rv_pipe[MLAT-2:0], mem_req && !mem_we};
            rd_pipe[0] <= mem_m[mem_addr];
            for (int k = 1; k < MLAT; k++) rd_pipe[k] <= rd_pipe[k-1];
        end
    end

    // Register-file model: synchronous read port.
    logic [EW-1:0] rf_m [NV][NE];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NV; v++)
                for (int e = 0; e < NE; e++) rf_m[v][e] <= rpat(v, e);
            rf_rdata <= '0;
        end else begin
            if (rf_we) rf_m[rf_wreg][rf_welem] <= rf_wdata;
            if (rf_re) rf_rdata <= rf_m[rf_rreg][rf_relem];
        end
    end

    logic [EW-1:0] exp_mem [MW];
    logic [EW-1:0] exp_rf [NV][NE];

    task automatic exp_init();
        for (int a = 0; a < MW; a++) exp_mem[a] = mpat(a);
        for (int v = 0; v < NV; v++)
            for (int e = 0; e < NE; e++) exp_rf[v][e] = rpat(v, e);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        int bad = 0;
        longint fa = 0, fe = 0;
        for (int a = 0; a < MW; a++)
            if (mem_m[a] !== exp_mem[a]) begin
                if (bad == 0) begin fa = longint'(mem_m[a]); fe = longint'(exp_mem[a]); end
                bad++;
            end
        for (int v = 0; v < NV; v++)
            for (int e = 0; e < NE; e++)
                if (rf_m[v][e] !== exp_rf[v][e]) begin
                    if (bad == 0) begin fa = longint'(rf_m[v][e]); fe = longint'(exp_rf[v][e]); end
                    bad++;
                end
        check(bad == 0, req, "memory/register contents (first mismatch)", fa, fe);
    endtask

    task automatic run_cmd(input logic st, input logic [AW-1:0] base,
                           input logic [1:0] vreg, input int vl, input bit poke);
        int busy_n = 0, first_we = -1, first_req = -1, nreq = 0, done_at = -1;
        int exp_busy = st ? vl + 1 : vl + LAT;
        for (int i = 0; i < vl; i++) begin
            if (st) exp_mem[(int'(base) + i) % MW] = exp_rf[vreg][i];
            else    exp_rf[vreg][i] = exp_mem[(int'(base) + i) % MW];
        end
        @(negedge clk);
        check(cmd_ready == 1'b1, "R2", "cmd_ready before command", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_store = st; cmd_base = base; cmd_vreg = vreg; cmd_vl = 7'(vl);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy == 1'b1, "R2", "busy in first cycle after accept", busy, 1);
        for (int i = 0; i < 200 && done_at < 0; i++) begin
            if (busy) busy_n++;
            if (rf_we && first_we < 0) first_we = i;
            if (mem_req) begin
                nreq++;
                if (first_req < 0) first_req = i;
            end
            if (done) done_at = i;
            if (poke && i == 3) begin
                check(cmd_ready == 1'b0, "R8", "cmd_ready while busy", cmd_ready, 0);
                cmd_valid = 1'b1; cmd_store = 1'b1; cmd_base = '0; cmd_vreg = 2'd0; cmd_vl = 7'd8;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
        end
        check(busy_n == exp_busy, "R8", "busy cycle count", busy_n, exp_busy);
        check(done_at == exp_busy, "R9", "done cycle", done_at, exp_busy);
        check(done == 1'b0 && busy == 1'b0, "R9", "done one cycle then idle", done, 0);
        check(nreq == vl, "R7", "memory request count", nreq, vl);
        if (st) begin
            check(first_req == 1, "R6", "first store write cycle", first_req, 1);
            compare_all("R6");
        end else begin
            check(first_req == 0, "R4", "first load request cycle", first_req, 0);
            check(first_we == LAT, "R5", "first register write cycle", first_we, LAT);
            compare_all("R5");
        end
    endtask

    task automatic bad_len(input int vl);
        int acts = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_store = 1'b0; cmd_base = 8'd10; cmd_vreg = 2'd1; cmd_vl = 7'(vl);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy == 1'b0, "R3", "busy after illegal length", busy, 0);
        for (int i = 0; i < LAT + 4; i++) begin
            if (mem_req || rf_we || rf_re || busy) acts++;
            @(negedge clk);
        end
        check(acts == 0, "R3", "activity after illegal length", acts, 0);
        compare_all("R3");
    endtask

    typedef struct packed {
        logic       st;
        logic [7:0] base;
        logic [1:0] vreg;
        logic [6:0] vl;
    } vec_t;

    localparam int NT = 8;
    localparam vec_t TBL [NT] = '{
        '{st: 1'b0, base: 8'd16,  vreg: 2'd1, vl: 7'd64},
        '{st: 1'b0, base: 8'd250, vreg: 2'd2, vl: 7'd10},
        '{st: 1'b0, base: 8'd0,   vreg: 2'd0, vl: 7'd1},
        '{st: 1'b1, base: 8'd100, vreg: 2'd3, vl: 7'd5},
        '{st: 1'b1, base: 8'd200, vreg: 2'd1, vl: 7'd64},
        '{st: 1'b0, base: 8'd5,   vreg: 2'd3, vl: 7'd33},
        '{st: 1'b1, base: 8'd40,  vreg: 2'd2, vl: 7'd1},
        '{st: 1'b0, base: 8'd128, vreg: 2'd0, vl: 7'd63}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        exp_init();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy && !done && !mem_req && !rf_we && !rf_re && cmd_ready, "R1",
              "idle outputs after reset", {busy, done, mem_req, rf_we, rf_re, cmd_ready}, 1);
        compare_all("R1");

        // R3: illegal lengths
        bad_len(0);
        bad_len(65);
        bad_len(127);

        // Table of transfers (R2, R4..R9); busy-time command poke on long ones
        for (int t = 0; t < NT; t++)
            run_cmd(TBL[t].st, TBL[t].base, TBL[t].vreg, int'(TBL[t].vl),
                    (TBL[t].st ? int'(TBL[t].vl) + 1 : int'(TBL[t].vl) + LAT) > 5);

        // R1: reset in the middle of a load
        @(negedge clk);
        cmd_valid = 1'b1; cmd_store = 1'b0; cmd_base = 8'd0; cmd_vreg = 2'd1; cmd_vl = 7'd64;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_init();
        @(negedge clk);
        check(!busy && !done && !mem_req && !rf_we && !rf_re && cmd_ready, "R1",
              "idle outputs after mid-transfer reset", {busy, done, mem_req, rf_we, rf_re, cmd_ready}, 1);

        // Recovery after reset: short load, then a store of it
        run_cmd(1'b0, 8'd60, 2'd2, 4, 1'b1);
        run_cmd(1'b1, 8'd252, 2'd2, 4, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule